// File: doc/BRIEF.md
# Coprocessor Instruction Handshake Sequencer

This block sits on the core side of a coprocessor port and carries one coprocessor instruction at a time through a response-driven handshake. A single `start` cycle hands it the instruction class, the target coprocessor number, a word address and a source operand. The block then opens the exchange with an opening request and follows the coprocessor's two-bit reply. A busy reply costs one idle slot, followed by a repeated request. A refusal ends the instruction as undefined. An accepting reply moves the block into the class-specific phase: a plain completion for operations and register moves, or a word-by-word memory stream for loads and stores.

During each idle slot of the busy wait the block looks at the core's exception lines. If something is pending, it sends an interrupt notice and gives up the instruction, reporting which event won by priority. Coprocessor numbers 10 and 11 never reach the handshake. They are handed to a local floating-point path through a one-cycle dispatch pulse. Every instruction ends with a one-cycle `done` strobe carrying a two-bit status.

Top module: `cp_xfer_seq`

## Requirements
- R1: If the permission bit `cp_allow[cp_num_in]` is clear for a coprocessor number other than 10 or 11, the instruction finishes with status 1 (undefined) and no request is ever driven on `cp_req`.
- R2: Coprocessor numbers 10 and 11 bypass the handshake, even if their permission bit is clear. `fp_go` and `done` pulse together with status 0, and `cp_req` stays 0.
- R3: An accepted `start` (only while `busy` is low) drives `cp_req`=1 (opening request) in the next cycle. A `start` pulse that arrives while `busy` is high is ignored.
- R4: Reply codes on `cp_resp` are 0 busy, 1 cannot, 2 increment, 3 done. A busy reply to a request with code 1 or 2 yields exactly one cycle with `cp_req`=0, followed by a re-request with code 2.
- R5: The pending condition is `rst_req`, or `fiq_req` with `fiq_mask` low, or `irq_req` with `irq_mask` low. It is sampled only in the idle slot of a busy wait. When it is true, the next cycle drives `cp_req`=3 (interrupt notice) and the instruction ends with status 2 (abandoned).
- R6: An abandoned instruction reports `cause`. The encoding is 1 for a reset request, 2 for a fast interrupt and 3 for a normal interrupt, with priority in that order. Completions that are not abandoned report 0.
- R7: A cannot reply to the opening request or to a re-request ends the instruction with status 1.
- R8: A load (`kind_in`=0) sends one transfer notice (`cp_req`=4). It then drives data requests (`cp_req`=5) with `mem_re` high and `cp_wdata` equal to the memory word at `mem_addr`. Each increment reply adds 4 to the address and repeats the data request.
- R9: A store (`kind_in`=1) drives data requests with `mem_we` high, writing `cp_rdata` to `mem_addr`. Each increment reply adds 4 and repeats the write.
- R10: A store whose address has a bit set at or above bit `LEGAL_AW` (26), or lies below `VEC_BYTES` (32), ends with status 3 (aborted) and performs no write.
- R11: For a move to the coprocessor (`kind_in`=2), `src_in` is presented on `cp_wdata` with every opening request and re-request. For a move from it (`kind_in`=3), `result` takes `cp_rdata` from the accepting cycle. A data operation uses `kind_in`=4.
- R12: `done` is high for exactly one cycle, in the cycle after the final reply. `status` reads 0 done, 1 undefined, 2 abandoned or 3 aborted. Latency from `start` is fixed by the reply sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Launch one instruction |
| kind_in | input | 3 | Instruction class: 0 load, 1 store, 2 move to cp, 3 move from cp, 4 operation |
| cp_num_in | input | 4 | Target coprocessor number |
| addr_in | input | 32 | Starting word address for loads and stores |
| src_in | input | 32 | Operand for a move to the coprocessor |
| cp_allow | input | 16 | Per-coprocessor access permission bits |
| rst_req | input | 1 | Pending reset request |
| fiq_req | input | 1 | Fast interrupt request |
| fiq_mask | input | 1 | Fast interrupt disable |
| irq_req | input | 1 | Normal interrupt request |
| irq_mask | input | 1 | Normal interrupt disable |
| cp_req | output | 3 | Request code: 0 none, 1 opening, 2 re-request, 3 interrupt notice, 4 transfer notice, 5 data |
| cp_sel | output | 4 | Coprocessor number of the running instruction |
| cp_wdata | output | 32 | Data to the coprocessor |
| cp_resp | input | 2 | Coprocessor reply code |
| cp_rdata | input | 32 | Data from the coprocessor |
| mem_addr | output | 32 | Memory word address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, combinational from `mem_addr` |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion strobe |
| status | output | 2 | Completion status |
| cause | output | 2 | Event that caused an abandon |
| result | output | 32 | Word captured on a move from the coprocessor |
| fp_go | output | 1 | Dispatch pulse to the local floating-point path |

## Verification
Each request code is a decode of the registered state, so it appears in the cycle after the edge that took the previous reply. The bench drives replies at the falling edge and reads the request in the same half cycle. `done` follows the last reply by one edge. The expected latency is therefore 1 for bypassed or refused launches, 2 plus two per busy reply for accepted moves and operations, 4 for an abandoned wait, and one more per streamed word plus the transfer notice for loads. The bench measures the count of falling edges from the launch to `done` and compares it with that arithmetic, alongside the request counts, addresses, data and status.

// File: rtl/cpx_pkg.sv
`timescale 1ns/1ps
package cpx_pkg;
  localparam logic [2:0] REQ_NONE  = 3'd0;
  localparam logic [2:0] REQ_FIRST = 3'd1;
  localparam logic [2:0] REQ_BUSY  = 3'd2;
  localparam logic [2:0] REQ_INTR  = 3'd3;
  localparam logic [2:0] REQ_XFER  = 3'd4;
  localparam logic [2:0] REQ_DATA  = 3'd5;

  localparam logic [1:0] RSP_BUSY = 2'd0;
  localparam logic [1:0] RSP_CANT = 2'd1;
  localparam logic [1:0] RSP_INC  = 2'd2;
  localparam logic [1:0] RSP_DONE = 2'd3;

  localparam logic [2:0] K_LOAD   = 3'd0;
  localparam logic [2:0] K_STORE  = 3'd1;
  localparam logic [2:0] K_TOCP   = 3'd2;
  localparam logic [2:0] K_FROMCP = 3'd3;
  localparam logic [2:0] K_OP     = 3'd4;

  localparam logic [1:0] ST_DONE    = 2'd0;
  localparam logic [1:0] ST_UNDEF   = 2'd1;
  localparam logic [1:0] ST_ABANDON = 2'd2;
  localparam logic [1:0] ST_ABORT   = 2'd3;

  localparam logic [1:0] CAUSE_NONE = 2'd0;
  localparam logic [1:0] CAUSE_RST  = 2'd1;
  localparam logic [1:0] CAUSE_FIQ  = 2'd2;
  localparam logic [1:0] CAUSE_IRQ  = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_FIRST, S_WAIT, S_BREQ, S_INTR, S_XFER, S_LDATA, S_SDATA, S_FIN
  } seq_state_e;
endpackage

// File: rtl/cpx_int_arb.sv
`timescale 1ns/1ps
module cpx_int_arb
  import cpx_pkg::*;
(
  input  logic       rst_req,
  input  logic       fiq_req,
  input  logic       fiq_mask,
  input  logic       irq_req,
  input  logic       irq_mask,
  output logic       pending,
  output logic [1:0] cause
);
  logic fiq_live, irq_live;

  always_comb begin
    fiq_live = fiq_req & ~fiq_mask;
    irq_live = irq_req & ~irq_mask;
    pending  = rst_req | fiq_live | irq_live;
    if (rst_req)       cause = CAUSE_RST;
    else if (fiq_live) cause = CAUSE_FIQ;
    else if (irq_live) cause = CAUSE_IRQ;
    else               cause = CAUSE_NONE;
  end
endmodule

// File: rtl/cpx_addr_chk.sv
`timescale 1ns/1ps
module cpx_addr_chk #(
  parameter int AW        = 32,
  parameter int LEGAL_AW  = 26,
  parameter int VEC_BYTES = 32
) (
  input  logic [AW-1:0] addr,
  output logic          bad
);
  localparam logic [AW-1:0] VEC_LIM = AW'(VEC_BYTES);

  logic high_bad;
  logic vec_hit;

  generate
    if (LEGAL_AW < AW) begin : g_range
      assign high_bad = |addr[AW-1:LEGAL_AW];
    end else begin : g_full
      assign high_bad = 1'b0;
    end
  endgenerate

  assign vec_hit = (addr < VEC_LIM);
  assign bad     = high_bad | vec_hit;
endmodule

// File: rtl/cp_xfer_seq.sv
`timescale 1ns/1ps
module cp_xfer_seq
  import cpx_pkg::*;
#(
  parameter int DW        = 32,
  parameter int CPN       = 16,
  parameter int LEGAL_AW  = 26,
  parameter int VEC_BYTES = 32,
  parameter int FP_CP_LO  = 10,
  parameter int FP_CP_HI  = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     kind_in,
  input  logic [$clog2(CPN)-1:0] cp_num_in,
  input  logic [DW-1:0]  addr_in,
  input  logic [DW-1:0]  src_in,
  input  logic [CPN-1:0] cp_allow,
  input  logic           rst_req,
  input  logic           fiq_req,
  input  logic           fiq_mask,
  input  logic           irq_req,
  input  logic           irq_mask,
  output logic [2:0]     cp_req,
  output logic [$clog2(CPN)-1:0] cp_sel,
  output logic [DW-1:0]  cp_wdata,
  input  logic [1:0]     cp_resp,
  input  logic [DW-1:0]  cp_rdata,
  output logic [DW-1:0]  mem_addr,
  output logic           mem_re,
  output logic           mem_we,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           busy,
  output logic           done,
  output logic [1:0]     status,
  output logic [1:0]     cause,
  output logic [DW-1:0]  result,
  output logic           fp_go
);
  localparam int CW = $clog2(CPN);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);
  localparam logic [CW-1:0] FP_A = CW'(FP_CP_LO);
  localparam logic [CW-1:0] FP_B = CW'(FP_CP_HI);

  seq_state_e    state_q, state_d;
  logic [2:0]    kind_q;
  logic [CW-1:0] cpn_q;
  logic [DW-1:0] addr_q, addr_d;
  logic [DW-1:0] src_q;
  logic [DW-1:0] result_q;
  logic [1:0]    status_q, status_d;
  logic [1:0]    cause_q, cause_d;
  logic          local_q;

  logic cap_en, addr_en, res_en;
  logic is_fp, int_pend, addr_bad;
  logic [1:0] int_cause;

  assign is_fp = (cp_num_in == FP_A) || (cp_num_in == FP_B);

  cpx_int_arb u_arb (
    .rst_req  (rst_req),
    .fiq_req  (fiq_req),
    .fiq_mask (fiq_mask),
    .irq_req  (irq_req),
    .irq_mask (irq_mask),
    .pending  (int_pend),
    .cause    (int_cause)
  );

  cpx_addr_chk #(
    .AW        (DW),
    .LEGAL_AW  (LEGAL_AW),
    .VEC_BYTES (VEC_BYTES)
  ) u_chk (
    .addr (addr_q),
    .bad  (addr_bad)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    status_d = status_q;
    cause_d  = cause_q;
    cap_en   = 1'b0;
    addr_en  = 1'b0;
    res_en   = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          cap_en   = 1'b1;
          addr_en  = 1'b1;
          addr_d   = addr_in;
          cause_d  = CAUSE_NONE;
          status_d = ST_DONE;
          if (is_fp) begin
            state_d = S_FIN;
          end else if (!cp_allow[cp_num_in]) begin
            status_d = ST_UNDEF;
            state_d  = S_FIN;
          end else begin
            state_d = S_FIRST;
          end
        end
      end
      S_FIRST, S_BREQ: begin
        case (cp_resp)
          RSP_BUSY: state_d = S_WAIT;
          RSP_CANT: begin
            status_d = ST_UNDEF;
            state_d  = S_FIN;
          end
          default: begin
            case (kind_q)
              K_LOAD:  state_d = S_XFER;
              K_STORE: begin
                if (addr_bad) begin
                  status_d = ST_ABORT;
                  state_d  = S_FIN;
                end else begin
                  state_d = S_SDATA;
                end
              end
              K_FROMCP: begin
                res_en  = 1'b1;
                state_d = S_FIN;
              end
              default: state_d = S_FIN;
            endcase
          end
        endcase
      end
      S_WAIT: begin
        if (int_pend) begin
          cause_d = int_cause;
          state_d = S_INTR;
        end else begin
          state_d = S_BREQ;
        end
      end
      S_INTR: begin
        status_d = ST_ABANDON;
        state_d  = S_FIN;
      end
      S_XFER: state_d = S_LDATA;
      S_LDATA, S_SDATA: begin
        if (cp_resp == RSP_INC) begin
          addr_en = 1'b1;
          addr_d  = addr_q + STEP;
        end else begin
          state_d = S_FIN;
        end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      kind_q   <= K_OP;
      cpn_q    <= '0;
      addr_q   <= '0;
      src_q    <= '0;
      result_q <= '0;
      status_q <= ST_DONE;
      cause_q  <= CAUSE_NONE;
      local_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      cause_q  <= cause_d;
      if (cap_en) begin
        kind_q  <= kind_in;
        cpn_q   <= cp_num_in;
        src_q   <= src_in;
        local_q <= is_fp;
      end
      if (addr_en) addr_q   <= addr_d;
      if (res_en)  result_q <= cp_rdata;
    end
  end

  // outputs
  always_comb begin
    case (state_q)
      S_FIRST:          cp_req = REQ_FIRST;
      S_BREQ:           cp_req = REQ_BUSY;
      S_INTR:           cp_req = REQ_INTR;
      S_XFER:           cp_req = REQ_XFER;
      S_LDATA, S_SDATA: cp_req = REQ_DATA;
      default:          cp_req = REQ_NONE;
    endcase
    if (state_q == S_LDATA)
      cp_wdata = mem_rdata;
    else if ((state_q == S_FIRST || state_q == S_BREQ) && kind_q == K_TOCP)
      cp_wdata = src_q;
    else
      cp_wdata = '0;
    mem_re    = (state_q == S_LDATA);
    mem_we    = (state_q == S_SDATA);
    mem_wdata = (state_q == S_SDATA) ? cp_rdata : '0;
  end

  assign cp_sel   = cpn_q;
  assign mem_addr = addr_q;
  assign busy     = (state_q != S_IDLE);
  assign done     = (state_q == S_FIN);
  assign status   = status_q;
  assign cause    = cause_q;
  assign result   = result_q;
  assign fp_go    = (state_q == S_FIN) && local_q;

  AST_DENIED_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !is_fp && !cp_allow[cp_num_in]) |=> (done && status == ST_UNDEF)); // R1
  AST_FIRST_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !is_fp && cp_allow[cp_num_in]) |=> (cp_req == REQ_FIRST)); // R3
  AST_BUSY_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ((cp_req == REQ_FIRST || cp_req == REQ_BUSY) && cp_resp == RSP_BUSY) |=> (cp_req == REQ_NONE && busy)); // R4
  AST_INTR_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_req == REQ_INTR) |=> (done && status == ST_ABANDON)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_req == REQ_DATA && cp_resp == RSP_INC) |=> (mem_addr == $past(mem_addr) + STEP)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
endmodule

// File: tb/tb_cp_xfer_seq.sv
`timescale 1ns/1ps
module tb_cp_xfer_seq;
  import cpx_pkg::*;

  localparam logic [31:0] MK = 32'h5A5A_0000;

  logic        clk, rst_n, start;
  logic [2:0]  kind_in;
  logic [3:0]  cp_num_in;
  logic [31:0] addr_in, src_in;
  logic [15:0] cp_allow;
  logic        rst_req, fiq_req, fiq_mask, irq_req, irq_mask;
  logic [2:0]  cp_req;
  logic [3:0]  cp_sel;
  logic [31:0] cp_wdata;
  logic [1:0]  cp_resp;
  logic [31:0] cp_rdata, mem_addr, mem_wdata, mem_rdata, result;
  logic        mem_re, mem_we, busy, done, fp_go;
  logic [1:0]  status, cause;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  cp_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .kind_in(kind_in),
    .cp_num_in(cp_num_in), .addr_in(addr_in), .src_in(src_in),
    .cp_allow(cp_allow), .rst_req(rst_req), .fiq_req(fiq_req),
    .fiq_mask(fiq_mask), .irq_req(irq_req), .irq_mask(irq_mask),
    .cp_req(cp_req), .cp_sel(cp_sel), .cp_wdata(cp_wdata),
    .cp_resp(cp_resp), .cp_rdata(cp_rdata), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .status(status),
    .cause(cause), .result(result), .fp_go(fp_go)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always_comb mem_rdata = mem_addr ^ MK;

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  task automatic run_op(input logic [2:0] kind, input int cpn,
                        input logic [31:0] base, input logic [31:0] src,
                        input int nb, input logic [1:0] fin, input int ninc,
                        input bit poke);
    bit is_local, denied, pend, ebad, fiq_l, irq_l;
    int e_first, e_busy, e_intr, e_xfer, e_data, e_gap, e_lat, e_wr;
    int n_first, n_busy, n_intr, n_xfer, n_data, n_gap, n_wr;
    int lat, bc, dc;
    logic [1:0] e_stat, e_cause, g_stat, g_cause;
    logic g_fp;
    logic [31:0] g_res, exp_a;
    bit seen;
    is_local = (cpn == 10 || cpn == 11);
    denied   = !cp_allow[cpn];
    fiq_l    = fiq_req && !fiq_mask;
    irq_l    = irq_req && !irq_mask;
    pend     = rst_req || fiq_l || irq_l;
    ebad     = (base[31:26] != 6'd0) || (base < 32'd32);
    e_first = 0; e_busy = 0; e_intr = 0; e_xfer = 0; e_data = 0; e_gap = 0; e_wr = 0;
    e_stat = ST_DONE; e_cause = CAUSE_NONE; e_lat = 1;
    if (is_local) begin
      e_lat = 1;
    end else if (denied) begin
      e_stat = ST_UNDEF;
    end else begin
      e_first = 1;
      if (nb > 0 && pend) begin
        e_gap = 1; e_intr = 1; e_stat = ST_ABANDON; e_lat = 4;
        e_cause = rst_req ? CAUSE_RST : (fiq_l ? CAUSE_FIQ : CAUSE_IRQ);
      end else begin
        e_busy = nb; e_gap = nb; e_lat = 2 + 2 * nb;
        if (fin == RSP_CANT) begin
          e_stat = ST_UNDEF;
        end else if (kind == K_LOAD) begin
          e_xfer = 1; e_data = ninc + 1; e_lat = e_lat + ninc + 2;
        end else if (kind == K_STORE) begin
          if (ebad) e_stat = ST_ABORT;
          else begin
            e_data = ninc + 1; e_wr = ninc + 1; e_lat = e_lat + ninc + 1;
          end
        end
      end
    end

    n_first = 0; n_busy = 0; n_intr = 0; n_xfer = 0; n_data = 0; n_gap = 0; n_wr = 0;
    lat = 0; bc = 0; dc = 0; seen = 0;
    g_stat = 2'd0; g_cause = 2'd0; g_fp = 1'b0; g_res = '0;
    @(negedge clk);
    kind_in = kind; cp_num_in = cpn[3:0]; addr_in = base; src_in = src;
    start = 1'b1; cp_resp = RSP_BUSY; cp_rdata = 32'hD000_0000;
    while (!seen && lat <= 100) begin
      @(negedge clk);
      lat++;
      start = (poke && lat == 2) ? 1'b1 : 1'b0;
      if (mem_we) n_wr++;
      if (done) begin
        seen = 1; g_stat = status; g_cause = cause; g_fp = fp_go; g_res = result;
      end else begin
        case (cp_req)
          REQ_FIRST, REQ_BUSY: begin
            if (cp_req == REQ_FIRST) n_first++; else n_busy++;
            if (kind == K_TOCP) chk("R11", "cp_wdata on request", cp_wdata, src);
            if (bc < nb) begin cp_resp = RSP_BUSY; bc++; end
            else cp_resp = fin;
          end
          REQ_INTR: n_intr++;
          REQ_XFER: n_xfer++;
          REQ_DATA: begin
            n_data++;
            exp_a = base + 32'(4 * dc);
            if (kind == K_LOAD) begin
              chk("R8", "mem_re", {31'd0, mem_re}, 32'd1);
              chk("R8", "load word to cp", cp_wdata, exp_a ^ MK);
            end else begin
              chk("R9", "store address", mem_addr, exp_a);
              chk("R9", "store data", mem_wdata, 32'hD000_0000 + 32'(dc));
            end
            cp_resp = (dc < ninc) ? RSP_INC : RSP_DONE;
            dc++;
            cp_rdata = 32'hD000_0000 + 32'(dc);
          end
          default: if (busy) n_gap++;
        endcase
      end
    end
    start = 1'b0;
    if (!seen) chk("R12", "done never seen", 32'd0, 32'd1);
    chk("R12", "latency", lat, e_lat);
    chk("R12", "status", {30'd0, g_stat}, {30'd0, e_stat});
    chk("R6", "cause", {30'd0, g_cause}, {30'd0, e_cause});
    chk("R2", "fp_go", {31'd0, g_fp}, {31'd0, is_local});
    chk("R3", "opening requests", n_first, e_first);
    chk("R4", "re-requests", n_busy, e_busy);
    chk("R4", "idle slots", n_gap, e_gap);
    chk("R5", "interrupt notices", n_intr, e_intr);
    chk("R8", "transfer notices", n_xfer, e_xfer);
    chk("R8", "data requests", n_data, e_data);
    chk("R10", "memory writes", n_wr, e_wr);
    if (kind == K_FROMCP && e_stat == ST_DONE && !is_local && !denied)
      chk("R11", "result", g_res, 32'hD000_0000);
    if (denied && !is_local) chk("R1", "status undef", {30'd0, g_stat}, {30'd0, ST_UNDEF});
    if (fin == RSP_CANT && e_first == 1 && e_intr == 0)
      chk("R7", "cannot status", {30'd0, g_stat}, {30'd0, ST_UNDEF});
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3", "idle after done", {28'd0, busy, cp_req}, 32'd0);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; kind_in = K_OP; cp_num_in = 4'd0;
    addr_in = '0; src_in = '0; cp_allow = 16'hFFFF;
    rst_req = 0; fiq_req = 0; fiq_mask = 0; irq_req = 0; irq_mask = 0;
    cp_resp = RSP_BUSY; cp_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R12", "reset done/busy", {30'd0, done, busy}, 32'd0);
    chk("R3", "reset cp_req", {29'd0, cp_req}, 32'd0);
    chk("R9", "reset mem strobes", {30'd0, mem_we, mem_re}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 5; k++)
      for (int nb = 0; nb < 3; nb++)
        for (int f = 1; f < 4; f++)
          for (int ni = 0; ni < ((k < 2) ? 3 : 1); ni++)
            run_op(3'(k), 3, 32'h0000_0100, 32'h1234_0000 + 32'(k * 16 + nb),
                   nb, 2'(f), ni, nb == 2);

    // R1: permission denied
    cp_allow[5] = 1'b0;
    run_op(K_OP, 5, 32'h100, 32'h0, 1, RSP_DONE, 0, 0);
    run_op(K_STORE, 5, 32'h100, 32'h0, 0, RSP_DONE, 1, 0);
    cp_allow[5] = 1'b1;
    // R2: local floating-point path
    cp_allow[10] = 1'b0;
    run_op(K_LOAD, 10, 32'h100, 32'h0, 2, RSP_DONE, 1, 0);
    run_op(K_STORE, 11, 32'h100, 32'h0, 2, RSP_DONE, 1, 0);
    cp_allow[10] = 1'b1;
    // R5 / R6: interrupts in the busy wait
    irq_req = 1;
    run_op(K_OP, 3, 32'h100, 32'h0, 0, RSP_DONE, 0, 0);
    run_op(K_OP, 3, 32'h100, 32'h0, 2, RSP_DONE, 0, 0);
    irq_mask = 1;
    run_op(K_LOAD, 3, 32'h100, 32'h0, 2, RSP_DONE, 1, 0);
    fiq_req = 1;
    run_op(K_OP, 3, 32'h100, 32'h0, 1, RSP_DONE, 0, 0);
    irq_mask = 0;
    run_op(K_TOCP, 3, 32'h100, 32'hABCD, 1, RSP_DONE, 0, 0);
    rst_req = 1;
    run_op(K_OP, 3, 32'h100, 32'h0, 1, RSP_DONE, 0, 0);
    rst_req = 0; fiq_mask = 1;
    run_op(K_FROMCP, 3, 32'h100, 32'h0, 2, RSP_DONE, 0, 0);
    irq_req = 0; fiq_req = 0; fiq_mask = 0; irq_mask = 0;
    // R10: store address checks
    run_op(K_STORE, 3, 32'h0000_001C, 32'h0, 0, RSP_DONE, 1, 0);
    run_op(K_STORE, 3, 32'h0000_0020, 32'h0, 1, RSP_DONE, 1, 0);
    run_op(K_STORE, 3, 32'h0400_0000, 32'h0, 0, RSP_INC, 2, 0);
    run_op(K_STORE, 3, 32'h03FF_FFF0, 32'h0, 0, RSP_DONE, 2, 0);
    run_op(K_LOAD, 3, 32'h0000_0004, 32'h0, 0, RSP_DONE, 1, 0);

    summary();
    $finish;
  end
endmodule